// File: doc/BRIEF.md
# Power, Reset and Clock State Controller

This block steps a device through three power states: held in reset, idle, and normal operation. An active-low external reset drops the block into the reset state at once, without waiting for a clock edge. Leaving reset is a clocked process. The released reset first passes through a two-flop synchronizer. A counter then holds the internal core reset for a fixed stretch of sixteen more clock cycles. While reset is held, two configuration strap pins are sampled. Their last sampled values are kept for the rest of the session.

After the core reset is released, the block enters normal operation. It raises a sticky ready interrupt that tells the external host it may start programming. The host can write a device-idle bit and a power-management-idle bit. Setting the device-idle bit sends the block to idle. In idle the clock enable and register access are removed, and a sleep request goes to a companion power-management device only if the power-management-idle bit is also set. A wake-up input is synchronized by logic that stays clocked during idle. It returns the block to normal operation, and it is ignored while the block is already in normal operation.

Top module: `prc_state_ctl`

## Requirements
- R1: While `ext_rst_n` is low, the block is in reset: `core_rst`=1 and `clk_en`, `reg_acc_en`, `sleep_o`, `rdy_irq` are 0. This takes effect as soon as `ext_rst_n` falls, without a clock edge, from any state.
- R2: After `ext_rst_n` rises, `core_rst` stays 1 through the 17th rising clock edge and falls at the 18th. This is two synchronizer stages plus a 16-cycle stretch.
- R3: The strap pins are sampled on every clock edge while the synchronized reset is low. `strap_ref_sel`=1 selects the 19.2 MHz external clock input and 0 selects the 24 MHz crystal. `strap_if_sel`=0 selects the serial host interface and 1 is reserved. Pin changes after `core_rst` falls do not change the outputs.
- R4: On the first clock edge after `core_rst` falls, the block enters normal operation: `clk_en`=1, `reg_acc_en`=1 and `rdy_irq`=1.
- R5: `rdy_irq` stays set until `rdy_clr` is seen high at a clock edge during normal operation, which clears it.
- R6: In normal operation, a `dev_idle_wr` strobe with `dev_idle_val`=1 moves the block to idle at that edge: `clk_en`=0 and `reg_acc_en`=0. A strobe with `dev_idle_val`=0 leaves the block in normal operation.
- R7: In idle, `sleep_o` is 1 when the power-management-idle bit is 1 and 0 when it is 0. Outside idle, `sleep_o` is 0.
- R8: In idle, the strobes `pm_idle_wr`, `dev_idle_wr` and `rdy_clr` have no effect. The stored bits and `rdy_irq` keep their values.
- R9: In idle, a `wake_in` pulse of one cycle returns the block to normal operation on the third rising edge after `wake_in` rises: `clk_en`=1, `reg_acc_en`=1, `sleep_o`=0. After the second edge the block is still idle.
- R10: In normal operation, a `wake_in` pulse changes no output.
- R11: The power-management-idle bit keeps its last value written in normal operation across any number of idle and normal periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| ext_rst_n | input | 1 | External reset, active low, asynchronous assertion |
| strap_ref_in | input | 1 | Reference-clock strap pin |
| strap_if_in | input | 1 | Host-interface strap pin |
| dev_idle_wr | input | 1 | Write strobe for the device-idle bit |
| dev_idle_val | input | 1 | Value written to the device-idle bit |
| pm_idle_wr | input | 1 | Write strobe for the power-management-idle bit |
| pm_idle_val | input | 1 | Value written to the power-management-idle bit |
| rdy_clr | input | 1 | Write-one-to-clear strobe for the ready interrupt |
| wake_in | input | 1 | Wake-up event, asynchronous |
| core_rst | output | 1 | Internal core reset, active high |
| strap_ref_sel | output | 1 | Latched reference-clock strap |
| strap_if_sel | output | 1 | Latched host-interface strap |
| clk_en | output | 1 | Clock enable for the core |
| reg_acc_en | output | 1 | Register read/write access enable |
| sleep_o | output | 1 | Sleep request to the power-management device |
| rdy_irq | output | 1 | Sticky ready interrupt to the host |

## Verification
Several rules are checked by assertions on every cycle:
- sleep is never requested outside idle or without both idle bits set;
- the ready interrupt follows every exit from reset;
- normal operation is left only through a device-idle write;
- idle freezes the stored bits;
- the stretch counter stays in range and releases only at its last count;
- the latched straps never move after release.

Some behaviour can only be shown by the bench's scenarios:
- the exact 18-edge release and the three-edge wake latency;
- the reset taking effect between clock edges;
- writes in idle being ignored, which shows up only through later sleep behaviour;
- the bit value picked up from the strap pins.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    PS_RESET  = 2'd0,
    PS_IDLE   = 2'd1,
    PS_NORMAL = 2'd2
  } pstate_e;

  localparam int unsigned STRAP_W = 2;
endpackage

// File: rtl/prc_rst_sync.sv
module prc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/prc_bit_sync.sv
module prc_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], d};
  end

  assign q = sh_q[STAGES-1];
endmodule

// File: rtl/prc_rst_stretch.sv
module prc_rst_stretch #(
  parameter int unsigned CYCLES = 16
) (
  input  logic clk,
  input  logic arst_n,
  input  logic rel_n,
  output logic core_rst
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q    <= '0;
      core_rst <= 1'b1;
    end else if (core_rst && rel_n) begin
      if (cnt_q == LAST) core_rst <= 1'b0;
      else               cnt_q    <= cnt_q + 1'b1;
    end
  end

  AST_STRETCH_LEN: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(core_rst) |-> ($past(cnt_q) == LAST)); // R2
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= LAST); // R2
endmodule

// File: rtl/prc_strap_latch.sv
module prc_strap_latch #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             hold,
  input  logic [WIDTH-1:0] pins,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (hold) q <= pins;
  end
endmodule

// File: rtl/prc_fsm.sv
module prc_fsm
  import prc_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic core_rst,
  input  logic dev_idle_wr,
  input  logic dev_idle_val,
  input  logic pm_idle_wr,
  input  logic pm_idle_val,
  input  logic rdy_clr,
  input  logic wake_s,
  output logic clk_en,
  output logic reg_acc_en,
  output logic sleep_o,
  output logic rdy_irq
);
  pstate_e state_q, state_d;
  logic    pm_q, pm_d, dev_q, dev_d, irq_d;

  always_comb begin
    state_d = state_q;
    pm_d    = pm_q;
    dev_d   = dev_q;
    irq_d   = rdy_irq;
    unique case (state_q)
      PS_RESET: begin
        if (!core_rst) begin
          state_d = PS_NORMAL;
          irq_d   = 1'b1;
        end
      end
      PS_NORMAL: begin
        if (pm_idle_wr)  pm_d  = pm_idle_val;
        if (rdy_clr)     irq_d = 1'b0;
        if (dev_idle_wr) dev_d = dev_idle_val;
        if (dev_idle_wr && dev_idle_val) state_d = PS_IDLE;
      end
      PS_IDLE: begin
        if (wake_s) begin
          state_d = PS_NORMAL;
          dev_d   = 1'b0;
        end
      end
      default: state_d = PS_RESET;
    endcase
    if (core_rst) state_d = PS_RESET;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q    <= PS_RESET;
      pm_q       <= 1'b0;
      dev_q      <= 1'b0;
      rdy_irq    <= 1'b0;
      clk_en     <= 1'b0;
      reg_acc_en <= 1'b0;
      sleep_o    <= 1'b0;
    end else begin
      state_q    <= state_d;
      pm_q       <= pm_d;
      dev_q      <= dev_d;
      rdy_irq    <= irq_d;
      clk_en     <= (state_d == PS_NORMAL);
      reg_acc_en <= (state_d == PS_NORMAL);
      sleep_o    <= (state_d == PS_IDLE) && pm_d && dev_d;
    end
  end

  AST_SLEEP_QUAL: assert property (@(posedge clk) disable iff (!arst_n)
    sleep_o |-> (!clk_en && !reg_acc_en && pm_q && dev_q)); // R7
  AST_IRQ_ON_EXIT: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == PS_RESET && !core_rst) |=> rdy_irq); // R4
  AST_NORMAL_STAYS: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == PS_NORMAL && !(dev_idle_wr && dev_idle_val)) |=> (state_q == PS_NORMAL)); // R10
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == PS_IDLE && !wake_s) |=> (state_q == PS_IDLE && $stable(pm_q) && $stable(rdy_irq))); // R8
endmodule

// File: rtl/prc_state_ctl.sv
module prc_state_ctl
  import prc_pkg::*;
#(
  parameter int unsigned RST_STAGES  = 2,
  parameter int unsigned WAKE_STAGES = 2,
  parameter int unsigned STRETCH_CYC = 16
) (
  input  logic clk,
  input  logic ext_rst_n,
  input  logic strap_ref_in,
  input  logic strap_if_in,
  input  logic dev_idle_wr,
  input  logic dev_idle_val,
  input  logic pm_idle_wr,
  input  logic pm_idle_val,
  input  logic rdy_clr,
  input  logic wake_in,
  output logic core_rst,
  output logic strap_ref_sel,
  output logic strap_if_sel,
  output logic clk_en,
  output logic reg_acc_en,
  output logic sleep_o,
  output logic rdy_irq
);
  logic               rel_n;
  logic               wake_s;
  logic [STRAP_W-1:0] strap_q;

  prc_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
    .clk(clk), .arst_n(ext_rst_n), .srst_n(rel_n)
  );

  prc_rst_stretch #(.CYCLES(STRETCH_CYC)) u_stretch (
    .clk(clk), .arst_n(ext_rst_n), .rel_n(rel_n), .core_rst(core_rst)
  );

  prc_strap_latch #(.WIDTH(STRAP_W)) u_strap (
    .clk(clk), .hold(!rel_n), .pins({strap_if_in, strap_ref_in}), .q(strap_q)
  );

  prc_bit_sync #(.STAGES(WAKE_STAGES)) u_wake_sync (
    .clk(clk), .arst_n(ext_rst_n), .d(wake_in), .q(wake_s)
  );

  prc_fsm u_fsm (
    .clk(clk), .arst_n(ext_rst_n), .core_rst(core_rst),
    .dev_idle_wr(dev_idle_wr), .dev_idle_val(dev_idle_val),
    .pm_idle_wr(pm_idle_wr), .pm_idle_val(pm_idle_val),
    .rdy_clr(rdy_clr), .wake_s(wake_s),
    .clk_en(clk_en), .reg_acc_en(reg_acc_en), .sleep_o(sleep_o), .rdy_irq(rdy_irq)
  );

  assign strap_ref_sel = strap_q[0];
  assign strap_if_sel  = strap_q[1];

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!ext_rst_n || core_rst)
    !$past(core_rst) |-> $stable(strap_q)); // R3
endmodule

// File: tb/prc_state_ctl_tb.sv
`timescale 1ns/1ps
module prc_state_ctl_tb_top;
  logic clk = 1'b0;
  logic ext_rst_n = 1'b0;
  logic strap_ref_in = 1'b1, strap_if_in = 1'b0;
  logic dev_idle_wr = 0, dev_idle_val = 0, pm_idle_wr = 0, pm_idle_val = 0;
  logic rdy_clr = 0, wake_in = 0;
  logic core_rst, strap_ref_sel, strap_if_sel, clk_en, reg_acc_en, sleep_o, rdy_irq;

  int total = 0, bad = 0;
  bit exp_norm = 0, exp_idle = 0, exp_pm = 0, exp_irq = 0;

  always #2.5 clk = ~clk;

  prc_state_ctl dut_i (
    .clk(clk), .ext_rst_n(ext_rst_n), .strap_ref_in(strap_ref_in), .strap_if_in(strap_if_in),
    .dev_idle_wr(dev_idle_wr), .dev_idle_val(dev_idle_val),
    .pm_idle_wr(pm_idle_wr), .pm_idle_val(pm_idle_val),
    .rdy_clr(rdy_clr), .wake_in(wake_in),
    .core_rst(core_rst), .strap_ref_sel(strap_ref_sel), .strap_if_sel(strap_if_sel),
    .clk_en(clk_en), .reg_acc_en(reg_acc_en), .sleep_o(sleep_o), .rdy_irq(rdy_irq)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_out();
    return {4'b0, exp_norm, exp_norm, exp_idle & exp_pm, exp_irq};
  endfunction

  function automatic logic [7:0] dut_out();
    return {4'b0, clk_en, reg_acc_en, sleep_o, rdy_irq};
  endfunction

  task automatic chk_state(input string tag);
    chk(tag, dut_out(), model_out());
  endtask

  task automatic run_reset(input bit ref_v, input bit if_v);
    @(posedge clk); #1;
    strap_ref_in = ref_v; strap_if_in = if_v;
    ext_rst_n = 1'b0;
    #1;
    chk("R1 async reset entry", {core_rst, clk_en, reg_acc_en, sleep_o, rdy_irq}, 8'h10);
    exp_norm = 0; exp_idle = 0; exp_pm = 0; exp_irq = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) ext_rst_n = 1'b1;
    repeat (17) @(posedge clk);
    @(negedge clk) chk("R2 core reset held at edge 17", core_rst, 1);
    @(posedge clk);
    @(negedge clk) chk("R2 core reset released at edge 18", core_rst, 0);
    strap_ref_in = ~ref_v; strap_if_in = ~if_v;
    @(posedge clk);
    @(negedge clk);
    exp_norm = 1; exp_irq = 1;
    chk_state("R4 normal after release");
    chk("R3 straps latched", {strap_if_sel, strap_ref_sel}, {if_v, ref_v});
  endtask

  task automatic wr_pm(input bit v);
    @(negedge clk) begin pm_idle_wr = 1; pm_idle_val = v; end
    @(posedge clk);
    @(negedge clk) pm_idle_wr = 0;
    if (exp_norm) exp_pm = v;
    chk_state(exp_norm ? "R11 pm write in normal" : "R8 pm write in idle");
  endtask

  task automatic wr_dev(input bit v);
    @(negedge clk) begin dev_idle_wr = 1; dev_idle_val = v; end
    @(posedge clk);
    @(negedge clk) dev_idle_wr = 0;
    if (exp_norm && v) begin exp_norm = 0; exp_idle = 1; end
    chk_state(exp_idle ? "R6 R7 idle entry and sleep" : "R6 dev write");
  endtask

  task automatic clr_rdy();
    @(negedge clk) rdy_clr = 1;
    @(posedge clk);
    @(negedge clk) rdy_clr = 0;
    if (exp_norm) exp_irq = 0;
    chk_state(exp_norm ? "R5 ready clear" : "R8 ready clear in idle");
  endtask

  task automatic wake();
    @(negedge clk) wake_in = 1;
    @(posedge clk);
    @(negedge clk) wake_in = 0;
    @(posedge clk);
    @(negedge clk) chk_state("R9 no wake before third edge");
    @(posedge clk);
    @(negedge clk);
    if (exp_idle) begin exp_idle = 0; exp_norm = 1; end
    chk_state(exp_norm ? "R9 R10 wake result" : "R9 wake");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=hang exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state at start", {core_rst, clk_en, reg_acc_en, sleep_o, rdy_irq}, 8'h10);
    run_reset(1'b1, 1'b0);
    wr_pm(0);
    wr_dev(1);           // R7: idle without pm, sleep low
    wake();
    wr_pm(1);
    wr_dev(1);           // R7: sleep high
    wr_pm(0);            // R8: ignored
    clr_rdy();           // R8: ignored
    wr_dev(0);           // R8: ignored
    chk("R8 still idle", {clk_en, sleep_o, rdy_irq}, 3'b011);
    wake();
    wr_dev(1);           // R11: pm still 1
    chk("R11 pm retained", sleep_o, 1);
    wake();
    clr_rdy();
    wr_dev(0);
    wake();              // R10
    chk("R10 wake ignored in normal", {clk_en, reg_acc_en, sleep_o, rdy_irq}, 4'b1100);
    wr_dev(1);
    run_reset(1'b0, 1'b1);
    for (int i = 0; i < 80; i++) begin
      case ($urandom_range(0, 4))
        0: wr_pm(1'($urandom_range(0, 1)));
        1: wr_dev(1);
        2: wake();
        3: clr_rdy();
        default: wr_dev(0);
      endcase
    end
    chk("R3 straps kept", {strap_if_sel, strap_ref_sel}, 2'b10);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule